// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block does the arithmetic and logical work of the two-operand data-processing group of a compact instruction set. Each issued operation takes operands A and B, a 4-bit operation code and the current N/Z/C/V condition flags. One clock later it returns three things: the 32-bit result, a destination write-enable, and the next N/Z/C/V flags. Shifts, multi-cycle multiply timing and register-file access are outside this block.

Internally, one adder serves all the arithmetic operations. Subtraction is done as A plus NOT B plus a carry-in, so the carry it produces already means "no borrow". A bitwise unit and a single-cycle low-word multiplier provide the remaining results. A decode stage picks the result source and decides how the flags are updated. Three update classes exist:

- **keep**: the flags pass through unchanged.
- **NZ only**: N and Z follow the result; C and V pass through.
- **full NZCV**: all four flags are computed.

The decode stage also raises the write-enable. The output registers then either capture a new result (the **issue** transition) or hold their value (the **idle** transition).

Top module: `flag_alu`

## Requirements
- R1: While `rst_n` is low, and after reset with no issue, `result`, `flags_out`, `wr_en` and `done` read zero.
- R2: An operation presented with `issue` high appears on the outputs at the next rising edge, with `done` high. In a cycle without `issue`, the next edge brings `done` and `wr_en` low, and `result` and `flags_out` hold their value.
- R3: Add (`op`=0) and compare-negative (`op`=6) compute A+B. N is bit 31 of the result, Z means the result is zero, C is the unsigned carry out of bit 31, and V is signed overflow. The flags sit on `flags_in`/`flags_out` as bit 3=N, bit 2=Z, bit 1=C, bit 0=V.
- R4: Subtract (`op`=1) and compare (`op`=5) compute A−B. C is 1 when no borrow occurs (A ≥ B unsigned), V is signed overflow of the subtraction, and N and Z follow the result.
- R5: Add-with-carry (`op`=2) computes A+B+C_in and sets all four flags as an addition.
- R6: Subtract-with-carry (`op`=3) computes A−B−(NOT C_in). C is 1 when A ≥ B+(NOT C_in) unsigned, and V is signed overflow.
- R7: Negate (`op`=4) computes 0−B and sets flags as a subtraction: C=1 only when B=0, and V=1 only when B=0x80000000.
- R8: Compare, compare-negative and bit-test (`op`=7, A AND B) update the flags and drive the value on `result`, but hold `wr_en` low. Every other defined code raises `wr_en`.
- R9: AND (`op`=8), OR (`op`=9), XOR (`op`=10), bit-clear (`op`=11, A AND NOT B) and move-not (`op`=12, NOT B) set N and Z from the result and copy C and V from `flags_in`.
- R10: Multiply (`op`=13) returns the low 32 bits of A×B in one cycle. It sets N and Z and copies C and V.
- R11: Codes 14 and 15 are no-ops: `result` reads 0, `wr_en` stays low, and `flags_out` equals `flags_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Operation presented this cycle |
| op | input | 4 | Operation code |
| a | input | 32 | Operand A |
| b | input | 32 | Operand B |
| flags_in | input | 4 | Current N,Z,C,V |
| result | output | 32 | Registered result |
| wr_en | output | 1 | Write the destination register |
| flags_out | output | 4 | Next N,Z,C,V |
| done | output | 1 | Outputs carry a new operation |

## Verification
The assertions assume that `issue`, `op`, the operands and `flags_in` are stable at each rising edge and known once reset is released. They also assume that `issue` stays low during reset. The stimulus meets these conditions by driving every input on the falling edge only and by holding `issue` low until after `rst_n` rises. No restriction is placed on operand or flag values: the directed cases reach carry, borrow, overflow and zero boundaries, and the random phase draws all sixteen codes and all flag patterns.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_ADC = 4'd2,
        OP_SBC = 4'd3,
        OP_NEG = 4'd4,
        OP_CMP = 4'd5,
        OP_CMN = 4'd6,
        OP_TST = 4'd7,
        OP_AND = 4'd8,
        OP_ORR = 4'd9,
        OP_XOR = 4'd10,
        OP_BIC = 4'd11,
        OP_MVN = 4'd12,
        OP_MUL = 4'd13
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    typedef enum logic [1:0] {
        CIN_ZERO,
        CIN_ONE,
        CIN_FLAG
    } cin_sel_e;

    typedef enum logic [1:0] {
        RSEL_NONE,
        RSEL_ARITH,
        RSEL_LOGIC,
        RSEL_MUL
    } rsel_e;

    typedef enum logic [1:0] {
        FUPD_KEEP,
        FUPD_NZ,
        FUPD_NZCV
    } fupd_e;

    typedef enum logic [2:0] {
        LG_AND,
        LG_OR,
        LG_XOR,
        LG_BIC,
        LG_NOTB
    } lgc_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    localparam int MSB = W - 1;

    logic [W:0] wide;

    assign wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    assign sum  = wide[MSB:0];
    assign cout = wide[W];
    // Signed overflow: like-signed inputs yield an oppositely signed sum.
    assign ovf  = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import flag_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  lgc_e         sel,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (sel)
            LG_AND:  y = a & b;
            LG_OR:   y = a | b;
            LG_XOR:  y = a ^ b;
            LG_BIC:  y = a & ~b;
            LG_NOTB: y = ~b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/alu_mul.sv
module alu_mul #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] p
);
    localparam int PW = 2 * W;

    logic [PW-1:0] full;

    assign full = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    assign p    = full[W-1:0];
endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         issue,
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [3:0]   flags_in,
    output logic [W-1:0] result,
    output logic         wr_en,
    output logic [3:0]   flags_out,
    output logic         done
);
    localparam int MSB = W - 1;

    nzcv_t    fin;
    cin_sel_e cin_sel;
    rsel_e    rsel;
    fupd_e    fupd;
    lgc_e     lsel;
    logic     x_zero, inv_b, we_c;

    logic [W-1:0] add_x, add_y, add_s, lg_y, mul_p, res_c;
    logic         add_cin, add_co, add_v;
    nzcv_t        nf;

    logic [W-1:0] res_q;
    nzcv_t        flags_q;
    logic         wr_q, done_q;

    assign fin = nzcv_t'(flags_in);

    // Decode: route the adder, choose the result and flag class.
    always_comb begin
        x_zero  = 1'b0;
        inv_b   = 1'b0;
        cin_sel = CIN_ZERO;
        rsel    = RSEL_NONE;
        fupd    = FUPD_KEEP;
        lsel    = LG_AND;
        we_c    = 1'b0;
        unique case (op)
            OP_ADD: begin rsel = RSEL_ARITH; fupd = FUPD_NZCV; we_c = 1'b1; end
            OP_SUB: begin rsel = RSEL_ARITH; fupd = FUPD_NZCV; we_c = 1'b1;
                          inv_b = 1'b1; cin_sel = CIN_ONE; end
            OP_ADC: begin rsel = RSEL_ARITH; fupd = FUPD_NZCV; we_c = 1'b1;
                          cin_sel = CIN_FLAG; end
            OP_SBC: begin rsel = RSEL_ARITH; fupd = FUPD_NZCV; we_c = 1'b1;
                          inv_b = 1'b1; cin_sel = CIN_FLAG; end
            OP_NEG: begin rsel = RSEL_ARITH; fupd = FUPD_NZCV; we_c = 1'b1;
                          x_zero = 1'b1; inv_b = 1'b1; cin_sel = CIN_ONE; end
            OP_CMP: begin rsel = RSEL_ARITH; fupd = FUPD_NZCV;
                          inv_b = 1'b1; cin_sel = CIN_ONE; end
            OP_CMN: begin rsel = RSEL_ARITH; fupd = FUPD_NZCV; end
            OP_TST: begin rsel = RSEL_LOGIC; fupd = FUPD_NZ; lsel = LG_AND; end
            OP_AND: begin rsel = RSEL_LOGIC; fupd = FUPD_NZ; lsel = LG_AND;  we_c = 1'b1; end
            OP_ORR: begin rsel = RSEL_LOGIC; fupd = FUPD_NZ; lsel = LG_OR;   we_c = 1'b1; end
            OP_XOR: begin rsel = RSEL_LOGIC; fupd = FUPD_NZ; lsel = LG_XOR;  we_c = 1'b1; end
            OP_BIC: begin rsel = RSEL_LOGIC; fupd = FUPD_NZ; lsel = LG_BIC;  we_c = 1'b1; end
            OP_MVN: begin rsel = RSEL_LOGIC; fupd = FUPD_NZ; lsel = LG_NOTB; we_c = 1'b1; end
            OP_MUL: begin rsel = RSEL_MUL;   fupd = FUPD_NZ; we_c = 1'b1; end
            default: ;
        endcase
    end

    always_comb begin
        unique case (cin_sel)
            CIN_ONE:  add_cin = 1'b1;
            CIN_FLAG: add_cin = fin.c;
            default:  add_cin = 1'b0;
        endcase
    end

    assign add_x = x_zero ? '0 : a;
    assign add_y = inv_b ? ~b : b;

    alu_addsub #(.W(W)) u_add (
        .x(add_x), .y(add_y), .cin(add_cin),
        .sum(add_s), .cout(add_co), .ovf(add_v)
    );

    alu_logic #(.W(W)) u_lgc (.a(a), .b(b), .sel(lsel), .y(lg_y));

    alu_mul #(.W(W)) u_mul (.a(a), .b(b), .p(mul_p));

    always_comb begin
        unique case (rsel)
            RSEL_ARITH: res_c = add_s;
            RSEL_LOGIC: res_c = lg_y;
            RSEL_MUL:   res_c = mul_p;
            default:    res_c = '0;
        endcase
    end

    always_comb begin
        unique case (fupd)
            FUPD_NZ:   nf = '{n: res_c[MSB], z: (res_c == '0), c: fin.c, v: fin.v};
            FUPD_NZCV: nf = '{n: res_c[MSB], z: (res_c == '0), c: add_co, v: add_v};
            default:   nf = fin;
        endcase
    end

    // Output registers: issue captures, idle holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= '0;
            flags_q <= '0;
            wr_q    <= 1'b0;
            done_q  <= 1'b0;
        end else if (issue) begin
            res_q   <= res_c;
            flags_q <= nf;
            wr_q    <= we_c;
            done_q  <= 1'b1;
        end else begin
            wr_q    <= 1'b0;
            done_q  <= 1'b0;
        end
    end

    assign result    = res_q;
    assign flags_out = flags_q;
    assign wr_en     = wr_q;
    assign done      = done_q;

    // R2
    issue_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> done);
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> (!done && !wr_en && $stable(result) && $stable(flags_out)));
    // R8
    cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (op == OP_CMP || op == OP_CMN || op == OP_TST)) |=> !wr_en);
    // R9
    logic_cv_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op >= OP_AND && op <= OP_MVN)
        |=> (flags_out[1:0] == $past(flags_in[1:0])));
    // R11
    unused_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op > OP_MUL) |=> (flags_out == $past(flags_in) && !wr_en));
    // R3
    nz_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op <= OP_MUL)
        |=> (flags_out[3] == result[MSB] && flags_out[2] == (result == '0)));
    // R7
    neg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op == OP_NEG && b == '0) |=> (flags_out[1] && !flags_out[0]));
endmodule

// File: tb/sim_flag_alu.sv
module sim_flag_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [31:0] a = '0, b = '0;
    logic [3:0]  flags_in = 4'd0;
    logic [31:0] result;
    logic        wr_en, done;
    logic [3:0]  flags_out;

    int checks = 0;
    int errors = 0;

    logic [31:0] e_res = '0;
    logic        e_we = 1'b0, e_done = 1'b0;
    logic [3:0]  e_flags = 4'd0;
    string       e_tag = "R1";

    always #5 clk = ~clk;

    flag_alu u0 (
        .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .a(a), .b(b),
        .flags_in(flags_in), .result(result), .wr_en(wr_en),
        .flags_out(flags_out), .done(done)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic bit ovf64(input longint s);
        return (s > 64'sd2147483647) || (s < -64'sd2147483648);
    endfunction

    // Behavioural reference of one operation.
    task automatic model(input int opc, input logic [31:0] x, input logic [31:0] y,
                         input logic [3:0] f, output logic [31:0] r, output logic we,
                         output logic [3:0] fo, output string tag);
        longint ux = longint'({32'd0, x});
        longint uy = longint'({32'd0, y});
        longint sx = longint'($signed(x));
        longint sy = longint'($signed(y));
        longint nc = f[1] ? 0 : 1;
        longint cc = f[1] ? 1 : 0;
        logic c = f[1], v = f[0];
        bit arith = 1'b1;
        we = 1'b1;
        r = '0;
        case (opc)
            0, 6: begin r = x + y; c = (ux + uy) > 64'hFFFFFFFF; v = ovf64(sx + sy);
                        tag = (opc == 0) ? "R3" : "R8"; we = (opc == 0); end
            1, 5: begin r = x - y; c = ux >= uy; v = ovf64(sx - sy);
                        tag = (opc == 1) ? "R4" : "R8"; we = (opc == 1); end
            2: begin r = x + y + 32'(cc); c = (ux + uy + cc) > 64'hFFFFFFFF;
                     v = ovf64(sx + sy + cc); tag = "R5"; end
            3: begin r = x - y - 32'(nc); c = ux >= (uy + nc);
                     v = ovf64(sx - sy - nc); tag = "R6"; end
            4: begin r = 32'd0 - y; c = (y == 0); v = ovf64(-sy); tag = "R7"; end
            7: begin r = x & y; arith = 0; we = 1'b0; tag = "R8"; end
            8: begin r = x & y;  arith = 0; tag = "R9"; end
            9: begin r = x | y;  arith = 0; tag = "R9"; end
            10: begin r = x ^ y; arith = 0; tag = "R9"; end
            11: begin r = x & ~y; arith = 0; tag = "R9"; end
            12: begin r = ~y;    arith = 0; tag = "R9"; end
            13: begin r = 32'((ux * uy) & 64'hFFFFFFFF); arith = 0; tag = "R10"; end
            default: begin r = '0; we = 1'b0; fo = f; tag = "R11"; end
        endcase
        if (opc <= 13) begin
            if (!arith) begin c = f[1]; v = f[0]; end
            fo = {r[31], (r == 0), c, v};
        end
    endtask

    // Drive at a falling edge, compare at the next falling edge.
    task automatic step(input bit iss, input int opc, input logic [31:0] x,
                        input logic [31:0] y, input logic [3:0] f);
        issue = iss; op = 4'(opc); a = x; b = y; flags_in = f;
        if (iss) begin
            model(opc, x, y, f, e_res, e_we, e_flags, e_tag);
            e_done = 1'b1;
        end else begin
            e_we = 1'b0; e_done = 1'b0; e_tag = "R2";
        end
        @(negedge clk);
        check(e_tag, "result", result, e_res);
        check(e_tag, "wr_en", {31'd0, wr_en}, {31'd0, e_we});
        check(e_tag, "flags", {28'd0, flags_out}, {28'd0, e_flags});
        check("R2", "done", {31'd0, done}, {31'd0, e_done});
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "result", result, 32'd0);
        check("R1", "flags", {28'd0, flags_out}, 32'd0);
        check("R1", "done", {31'd0, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "wr_en", {31'd0, wr_en}, 32'd0);

        step(0, 0, 32'd7, 32'd9, 4'hF);                    // R2 idle
        step(1, 0, 32'hFFFFFFFF, 32'd1, 4'h0);             // R3 carry, zero
        step(1, 0, 32'h7FFFFFFF, 32'd1, 4'h0);             // R3 overflow
        step(0, 0, 32'd0, 32'd0, 4'h0);                    // R2 hold
        step(1, 1, 32'd5, 32'd5, 4'h0);                    // R4 no borrow
        step(1, 1, 32'd3, 32'd5, 4'hF);                    // R4 borrow
        step(1, 1, 32'h80000000, 32'd1, 4'h0);             // R4 overflow
        step(1, 2, 32'hFFFFFFFE, 32'd1, 4'h2);             // R5 carry in
        step(1, 2, 32'd10, 32'd20, 4'h0);                  // R5 no carry in
        step(1, 3, 32'd10, 32'd10, 4'h0);                  // R6 borrow in
        step(1, 3, 32'd10, 32'd10, 4'h2);                  // R6 no borrow in
        step(1, 4, 32'd0, 32'd0, 4'h0);                    // R7 B=0
        step(1, 4, 32'd0, 32'h80000000, 4'h0);             // R7 min value
        step(1, 4, 32'd0, 32'd1, 4'h2);                    // R7
        step(1, 5, 32'd4, 32'd4, 4'h0);                    // R8 compare
        step(1, 6, 32'hFFFFFFFF, 32'd1, 4'h0);             // R8 compare-negative
        step(1, 7, 32'hF0F0F0F0, 32'h0F0F0F0F, 4'h3);      // R8 bit-test
        step(1, 8, 32'hFFFF0000, 32'h00FFFF00, 4'h3);      // R9 C,V kept
        step(1, 11, 32'hFFFFFFFF, 32'hFFFFFFFF, 4'h1);     // R9 zero
        step(1, 12, 32'd0, 32'd0, 4'h2);                   // R9 negative
        step(1, 13, 32'h00010001, 32'h00010001, 4'h3);     // R10 wrap
        step(1, 13, 32'hFFFFFFFF, 32'hFFFFFFFF, 4'h0);     // R10
        step(1, 14, 32'd1, 32'd2, 4'hA);                   // R11
        step(1, 15, 32'd3, 32'd4, 4'h5);                   // R11

        for (int i = 0; i < 600; i++) begin
            bit iss = ($urandom % 5) != 0;
            int opc = int'($urandom % 16);
            logic [31:0] x = $urandom;
            logic [31:0] y = $urandom;
            if (($urandom % 4) == 0) y = x;
            if (($urandom % 8) == 0) x = 32'h80000000;
            step(iss, opc, x, y, 4'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule